// File: doc/BRIEF.md
# Boost-Gated Entropy Harvest Sequencer

This block controls a noise-based entropy source that runs from a switched boost supply and a storage capacitor. While the capacitor charges, the boost converter runs and its switching noise would bias the comparator. So the block never samples during that phase.

Once the supply monitor reports the upper level, the converter is switched off. The block then samples the synchronised comparator bit at a fixed rate, set by a clock-enable divider. It keeps sampling while the capacitor discharges, until the supply falls below the lower level.

A seed of a parameterised number of bits is gathered. If one quiet window is not long enough for the whole seed, the count carries over across further charge and harvest rounds. If charging does not reach the upper level within a cycle limit, the block reports a fault and shuts the converter off.

Top module: `entropy_harvest_seq`

## Requirements
- R1: After synchronous reset, `boost_en`, `bit_valid`, `bit_data`, `seed_done` and `charge_fault` are all 0, and the block waits for `start_req`.
- R2: A `start_req` seen at a clock edge while idle, done or faulted sets `boost_en` to 1 at that same edge.
- R3: The comparator input and both supply flags pass through two flip-flops before they are used. While charging, a 0-to-1 change of `sup_hi_raw` clears `boost_en` at the third rising edge after the change.
- R4: `bit_valid` is only ever 1 while `boost_en` is 0 and the block is in a harvest window.
- R5: In a harvest window, the first `bit_valid` pulse follows DIV_RATIO clock edges after `boost_en` falls. Later pulses are spaced DIV_RATIO cycles apart, and each lasts one cycle.
- R6: While harvesting, a 1-to-0 change of `sup_lo_raw` sets `boost_en` to 1 at the third rising edge after the change. No bit is sampled after that point.
- R7: `bit_data` on each pulse equals the comparator level that was presented at least three cycles earlier and held since. The bit count continues across charge and harvest rounds. `seed_done` rises together with pulse number SEED_BITS.
- R8: While `seed_done` is 1, `boost_en` stays 0, no pulses occur, and changes on the supply flags have no effect. A `start_req` clears `seed_done` and begins a new charge.
- R9: If `boost_en` stays 1 for CHARGE_LIMIT consecutive cycles without the upper flag, `charge_fault` goes to 1 and `boost_en` goes to 0 at the same edge.
- R10: `charge_fault` holds, with `boost_en` at 0, until a `start_req` clears it and restarts charging.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Request a new seed gather (one-cycle pulse) |
| cmp_raw | input | 1 | Comparator output from the noise pair, asynchronous |
| sup_hi_raw | input | 1 | 1 when the supply is at or above the upper level, asynchronous |
| sup_lo_raw | input | 1 | 1 when the supply is above the lower level, asynchronous |
| boost_en | output | 1 | Boost converter enable |
| bit_valid | output | 1 | One-cycle strobe for a sampled bit |
| bit_data | output | 1 | Sampled comparator bit |
| seed_done | output | 1 | Seed complete, held until the next start |
| charge_fault | output | 1 | Charge timeout, held until the next start |

## Verification
The bench builds the block with DIV_RATIO=4, SEED_BITS=10 and CHARGE_LIMIT=20. These values make every sample slot, both phase transitions and the timeout reachable within a few dozen cycles each.

With a ten-bit seed, the bench can gather six bits in a first window, cut that window short with the lower flag, and finish the last four bits after a second charge. The charge timeout is counted cycle by cycle against its exact limit. Each sampled bit is compared with a known ten-bit pattern that is fed to the comparator input.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_CHARGE  = 3'd1,
    PH_HARVEST = 3'd2,
    PH_DONE    = 3'd3,
    PH_FAULT   = 3'd4
  } phase_t;
endpackage

// File: rtl/hs_sync.sv
// Two-stage synchroniser for a bundle of independent asynchronous levels.
module hs_sync #(
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q_sync <= '0;
    end else begin
      stage1 <= d_async;
      q_sync <= stage1;
    end
  end
endmodule

// File: rtl/hs_tick_div.sv
// Clock-enable divider: one tick every DIV_RATIO cycles while run is high.
// The count restarts from zero whenever run is low.
module hs_tick_div #(
  parameter int DIV_RATIO = 977
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int DW = (DIV_RATIO > 2) ? $clog2(DIV_RATIO) : 1;
  localparam logic [DW-1:0] TOP = DW'(DIV_RATIO - 1);

  logic [DW-1:0] cnt;

  assign tick = run && (cnt == TOP);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/hs_phase_ctrl.sv
// Phase sequencer: charge, quiet harvest, done and fault, with registered outputs.
module hs_phase_ctrl
  import hs_pkg::*;
#(
  parameter int SEED_BITS    = 768,
  parameter int CHARGE_LIMIT = 2500000
) (
  input  logic clk,
  input  logic rst,
  input  logic start_req,
  input  logic cmp_s,
  input  logic hi_s,
  input  logic lo_s,
  input  logic tick,
  output logic harvesting,
  output logic boost_en,
  output logic bit_valid,
  output logic bit_data,
  output logic seed_done,
  output logic charge_fault
);
  localparam int CW = $clog2(SEED_BITS + 1);
  localparam int TW = $clog2(CHARGE_LIMIT + 1);
  localparam logic [CW-1:0] LAST_BIT = CW'(SEED_BITS - 1);
  localparam logic [TW-1:0] LAST_TMR = TW'(CHARGE_LIMIT - 1);

  phase_t        phase;
  logic [CW-1:0] nbits;
  logic [TW-1:0] timer;

  assign harvesting = (phase == PH_HARVEST);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase        <= PH_IDLE;
      nbits        <= '0;
      timer        <= '0;
      boost_en     <= 1'b0;
      bit_valid    <= 1'b0;
      bit_data     <= 1'b0;
      seed_done    <= 1'b0;
      charge_fault <= 1'b0;
    end else begin
      bit_valid <= 1'b0;
      case (phase)
        PH_IDLE, PH_DONE, PH_FAULT: begin
          if (start_req) begin
            phase        <= PH_CHARGE;
            boost_en     <= 1'b1;
            timer        <= '0;
            nbits        <= '0;
            seed_done    <= 1'b0;
            charge_fault <= 1'b0;
          end
        end
        PH_CHARGE: begin
          if (hi_s) begin
            phase    <= PH_HARVEST;
            boost_en <= 1'b0;
          end else if (timer == LAST_TMR) begin
            phase        <= PH_FAULT;
            boost_en     <= 1'b0;
            charge_fault <= 1'b1;
          end else begin
            timer <= timer + 1'b1;
          end
        end
        PH_HARVEST: begin
          if (!lo_s) begin
            phase    <= PH_CHARGE;
            boost_en <= 1'b1;
            timer    <= '0;
          end else if (tick) begin
            bit_valid <= 1'b1;
            bit_data  <= cmp_s;
            nbits     <= nbits + 1'b1;
            if (nbits == LAST_BIT) begin
              phase     <= PH_DONE;
              seed_done <= 1'b1;
            end
          end
        end
        default: begin
          phase    <= PH_IDLE;
          boost_en <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/entropy_harvest_seq.sv
module entropy_harvest_seq #(
  parameter int DIV_RATIO    = 977,
  parameter int SEED_BITS    = 768,
  parameter int CHARGE_LIMIT = 2500000
) (
  input  logic clk,
  input  logic rst,
  input  logic start_req,
  input  logic cmp_raw,
  input  logic sup_hi_raw,
  input  logic sup_lo_raw,
  output logic boost_en,
  output logic bit_valid,
  output logic bit_data,
  output logic seed_done,
  output logic charge_fault
);
  localparam int NSYNC = 3;

  logic [NSYNC-1:0] synced;
  logic             harvesting;
  logic             tick;

  hs_sync #(.WIDTH(NSYNC)) sync_i (
    .clk    (clk),
    .rst    (rst),
    .d_async({cmp_raw, sup_hi_raw, sup_lo_raw}),
    .q_sync (synced)
  );

  hs_tick_div #(.DIV_RATIO(DIV_RATIO)) div_i (
    .clk (clk),
    .rst (rst),
    .run (harvesting),
    .tick(tick)
  );

  hs_phase_ctrl #(
    .SEED_BITS   (SEED_BITS),
    .CHARGE_LIMIT(CHARGE_LIMIT)
  ) ctrl_i (
    .clk         (clk),
    .rst         (rst),
    .start_req   (start_req),
    .cmp_s       (synced[2]),
    .hi_s        (synced[1]),
    .lo_s        (synced[0]),
    .tick        (tick),
    .harvesting  (harvesting),
    .boost_en    (boost_en),
    .bit_valid   (bit_valid),
    .bit_data    (bit_data),
    .seed_done   (seed_done),
    .charge_fault(charge_fault)
  );
endmodule

// File: rtl/entropy_harvest_seq_chk.sv
module entropy_harvest_seq_chk (
  input logic clk,
  input logic rst,
  input logic start_req,
  input logic boost_en,
  input logic bit_valid,
  input logic seed_done,
  input logic charge_fault
);
  // R4
  quiet_sample_chk: assert property (@(posedge clk) disable iff (rst)
    bit_valid |-> !boost_en);

  // R5
  strobe_width_chk: assert property (@(posedge clk) disable iff (rst)
    bit_valid |=> !bit_valid);

  // R7
  done_with_last_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(seed_done) |-> bit_valid);

  // R8
  done_boost_off_chk: assert property (@(posedge clk) disable iff (rst)
    seed_done |-> !boost_en);

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (seed_done && !start_req) |=> seed_done);

  // R9
  fault_boost_off_chk: assert property (@(posedge clk) disable iff (rst)
    charge_fault |-> !boost_en);

  // R10
  fault_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (charge_fault && !start_req) |=> charge_fault);

  // R8
  exclusive_end_chk: assert property (@(posedge clk) disable iff (rst)
    !(seed_done && charge_fault));
endmodule

bind entropy_harvest_seq entropy_harvest_seq_chk chk_i (
  .clk         (clk),
  .rst         (rst),
  .start_req   (start_req),
  .boost_en    (boost_en),
  .bit_valid   (bit_valid),
  .seed_done   (seed_done),
  .charge_fault(charge_fault)
);

// File: tb/entropy_harvest_seq_tb_top.sv
`timescale 1ns/1ps
module entropy_harvest_seq_tb_top;
  localparam int DIV   = 4;
  localparam int NBITS = 10;
  localparam int LIMIT = 20;
  localparam logic [NBITS-1:0] PAT = 10'b1011001110;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_req = 1'b0;
  logic cmp_raw = 1'b0;
  logic sup_hi_raw = 1'b0;
  logic sup_lo_raw = 1'b0;
  logic boost_en, bit_valid, bit_data, seed_done, charge_fault;

  int n_chk = 0;
  int n_fail = 0;
  int idx = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  entropy_harvest_seq #(
    .DIV_RATIO(DIV), .SEED_BITS(NBITS), .CHARGE_LIMIT(LIMIT)
  ) dut_i (
    .clk(clk), .rst(rst), .start_req(start_req), .cmp_raw(cmp_raw),
    .sup_hi_raw(sup_hi_raw), .sup_lo_raw(sup_lo_raw),
    .boost_en(boost_en), .bit_valid(bit_valid), .bit_data(bit_data),
    .seed_done(seed_done), .charge_fault(charge_fault)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_start();
    start_req = 1'b1;
    step();
    start_req = 1'b0;
  endtask

  // Called at the negedge where boost_en was just seen falling.
  task automatic harvest(input int n);
    for (int k = 0; k < n; k++) begin
      for (int j = 1; j <= DIV; j++) begin
        step();
        if (j < DIV) chk(bit_valid == 1'b0, "R5 no early strobe", bit_valid, 0);
      end
      chk(bit_valid == 1'b1, "R5 strobe on slot", bit_valid, 1);
      chk(boost_en == 1'b0, "R4 boost off while sampling", boost_en, 0);
      chk(bit_data == PAT[idx], "R7 sampled data", bit_data, PAT[idx]);
      idx++;
      if (idx < NBITS) cmp_raw = PAT[idx];
    end
  endtask

  // Raise the upper flag; boost must fall at the third edge (R3).
  task automatic reach_upper();
    sup_hi_raw = 1'b1;
    sup_lo_raw = 1'b1;
    step();
    step();
    chk(boost_en == 1'b1, "R3 still charging before sync delay", boost_en, 1);
    step();
    chk(boost_en == 1'b0, "R3 boost off after upper flag", boost_en, 0);
    sup_hi_raw = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    step();
    step();
    rst = 1'b0;
    chk(boost_en == 0, "R1 boost_en reset", boost_en, 0);
    chk(bit_valid == 0, "R1 bit_valid reset", bit_valid, 0);
    chk(seed_done == 0, "R1 seed_done reset", seed_done, 0);
    chk(charge_fault == 0, "R1 charge_fault reset", charge_fault, 0);
    step();
    chk(boost_en == 0, "R1 idle without start", boost_en, 0);

    cmp_raw = PAT[0];
    pulse_start();
    chk(boost_en == 1, "R2 boost on after start", boost_en, 1);
    for (int i = 0; i < 4; i++) begin
      step();
      chk(bit_valid == 0, "R4 no strobe while charging", bit_valid, 0);
    end
    reach_upper();
    harvest(6);

    // Supply falls below the lower level mid-seed (R6).
    sup_lo_raw = 1'b0;
    step();
    step();
    chk(boost_en == 0, "R6 still harvesting before sync delay", boost_en, 0);
    step();
    chk(boost_en == 1, "R6 recharge after lower flag drop", boost_en, 1);
    for (int i = 0; i < 5; i++) begin
      step();
      chk(bit_valid == 0, "R6 no strobe after lower drop", bit_valid, 0);
    end
    chk(seed_done == 0, "R7 not done after partial window", seed_done, 0);

    reach_upper();
    harvest(4);
    chk(seed_done == 1, "R7 done with final bit", seed_done, 1);

    for (int i = 0; i < 12; i++) begin
      sup_hi_raw = i[0];
      sup_lo_raw = i[1];
      step();
      chk(bit_valid == 0 && boost_en == 0 && seed_done == 1,
          "R8 done holds, flags ignored", {bit_valid, boost_en, seed_done}, 1);
    end
    sup_hi_raw = 1'b0;
    sup_lo_raw = 1'b0;
    step();
    step();

    pulse_start();
    chk(seed_done == 0, "R8 start clears done", seed_done, 0);
    chk(boost_en == 1, "R2 restart after done", boost_en, 1);
    begin
      int c = 1;
      while (boost_en && c < 200) begin
        step();
        if (boost_en) c++;
      end
      chk(c == LIMIT, "R9 charge cycles before fault", c, LIMIT);
    end
    chk(charge_fault == 1, "R9 fault flagged", charge_fault, 1);
    sup_hi_raw = 1'b1;
    sup_lo_raw = 1'b1;
    for (int i = 0; i < 6; i++) begin
      step();
      chk(charge_fault == 1 && boost_en == 0, "R10 fault holds, boost off",
          {charge_fault, boost_en}, 2);
    end
    sup_hi_raw = 1'b0;
    sup_lo_raw = 1'b0;
    step();
    step();
    pulse_start();
    chk(charge_fault == 0, "R10 start clears fault", charge_fault, 0);
    chk(boost_en == 1, "R10 recharge after fault", boost_en, 1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule